// File: doc/BRIEF.md
# System Sleep State Sequencer

This block is the platform's power-state controller. It keeps track of the global power state: working, sleeping, soft off or mechanically off. It runs the ordered sequence of active-low control lines that takes the platform into a sleep level and brings it back out. Software or firmware selects a sleep kind and pulses a go strobe while the platform is working. The sequencer then steps through the control lines one at a time. Between steps it waits a programmable number of clock cycles. Part way through, it holds for a request/acknowledge exchange with the processor-side link.

Deeper sleep kinds assert more lines. Each line, once asserted, stays asserted while the following ones are added. A wake event in a resting sleep or soft-off state releases the lines in the reverse order, using the same per-level hold times. The sequencer returns to working once the link partner has withdrawn its acknowledge.

Losing the power-present input forces the mechanically-off state on the next clock edge. When power comes back, a configuration input selects whether the platform lands in soft off or goes straight to working.

Top module: `slp_seq_top`

## Requirements
- R1: While `rst` is high, and on the first edge after it, the block reports `gstate` = 3 (mechanical off). All seven control lines are driven low and `link_req` is low.
- R2: When `pwr_ok` is sampled high in the mechanical-off state, the next cycle shows one of two results. If `resume_on_power` = 0, it shows soft off (`gstate` = 2) with all lines low. If `resume_on_power` = 1, it shows working (`gstate` = 0) with all lines high.
- R3: `sleep_kind` encoding sets the number of asserted lines at rest. The encodings are: 0 = S1, giving 2 lines; 1 = S3, giving 5 lines; 2 = S4, giving 6 lines; 3 = S5, giving 7 lines. The resting `gstate` is 2 for S5 and 1 for the other three.
- R4: Lines are asserted strictly one at a time, in this order: `stop_clk_n`, `cpu_sleep_n`, `suspend_n`, `plat_rst_n`, `sleep3_n`, `sleep4_n`, `sleep5_n`. A line is never asserted while any line earlier in the order is released.
- R5: During entry, when m lines are asserted, that count holds for exactly `STEP_GAP[m-1]` cycles before the next line asserts. This applies to every step except the one that waits on the link.
- R6: `link_req` rises `STEP_GAP[0]` cycles after `stop_clk_n` falls. `cpu_sleep_n` falls on the cycle after `link_ack` is first sampled high.
- R7: A wake event in the resting state releases the highest asserted line in the next cycle. The remaining lines then release in reverse order. While m lines are asserted during exit, the count holds for `STEP_GAP[m-1]` cycles.
- R8: `link_req` falls in the same cycle that `stop_clk_n` is released. `gstate` returns to 0 one cycle after `link_ack` is first sampled low with all lines released.
- R9: `sleep_go` has no effect unless the block is in the working state. `wake_evt` has no effect in the working state.
- R10: Whenever `pwr_ok` is sampled low, the next cycle shows three things. `gstate` is 3, all lines are low and `link_req` is low.
- R11: `gstate` stays 0 during entry and changes to the resting code only after the hold time of the final level, `STEP_GAP[d-1]` cycles after the last line asserts. During exit it keeps the resting code until the working state is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Main power present |
| resume_on_power | input | 1 | Power-return policy: 1 = working, 0 = soft off |
| sleep_go | input | 1 | One-cycle sleep request strobe |
| sleep_kind | input | 2 | Requested sleep kind (0 S1, 1 S3, 2 S4, 3 S5) |
| wake_evt | input | 1 | One-cycle wake event |
| link_ack | input | 1 | Acknowledge from the processor-side link |
| link_req | output | 1 | Request to the processor-side link |
| stop_clk_n | output | 1 | Stop-clock, active low |
| cpu_sleep_n | output | 1 | Processor sleep, active low |
| suspend_n | output | 1 | Suspend status, active low |
| plat_rst_n | output | 1 | Platform reset, active low |
| sleep3_n | output | 1 | Level-3 sleep line, active low |
| sleep4_n | output | 1 | Level-4 sleep line, active low |
| sleep5_n | output | 1 | Level-5 sleep line, active low |
| gstate | output | 2 | Global state: 0 working, 1 sleeping, 2 soft off, 3 mechanical off |

## Verification
The properties assume a well-behaved link partner. It raises `link_ack` only in answer to `link_req`, drops it only after `link_req` falls, and never changes it in any other way. The bench models that partner with a random response latency of zero to three cycles, so every acknowledge in the run follows the protocol. The properties also assume that `sleep_go` and `wake_evt` are single-cycle pulses that arrive only in the intended states. The directed and random sequences issue them one at a time, and only once the previous sequence has settled. The two exceptions are the deliberate pulses that check that stray requests are ignored.

// File: rtl/slp_pkg.sv
package slp_pkg;

    localparam int NUM_LINES = 7;
    localparam int LVL_W     = $clog2(NUM_LINES + 1);

    typedef int unsigned gap_arr_t [NUM_LINES];

    typedef enum logic [1:0] {
        SK_S1 = 2'd0,
        SK_S3 = 2'd1,
        SK_S4 = 2'd2,
        SK_S5 = 2'd3
    } sleep_kind_e;

    typedef enum logic [1:0] {
        GS_WORK  = 2'd0,
        GS_SLEEP = 2'd1,
        GS_SOFT  = 2'd2,
        GS_MECH  = 2'd3
    } gstate_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WORK,
        ST_DOWN,
        ST_HAND,
        ST_REST,
        ST_UP,
        ST_RELEASE
    } seq_state_e;

    typedef struct packed {
        seq_state_e       st;
        logic [LVL_W-1:0] level;
        logic [LVL_W-1:0] target;
        logic             req;
        gstate_e          gs;
    } seq_regs_t;

    // level after which the link handshake is inserted
    localparam int HAND_LEVEL = 1;

    function automatic logic [LVL_W-1:0] depth_of(sleep_kind_e k);
        case (k)
            SK_S1:   return LVL_W'(2);
            SK_S3:   return LVL_W'(5);
            SK_S4:   return LVL_W'(6);
            default: return LVL_W'(NUM_LINES);
        endcase
    endfunction

    function automatic int unsigned max_gap(gap_arr_t g);
        int unsigned m = 1;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (g[i] > m) m = g[i];
        end
        return m;
    endfunction

endpackage

// File: rtl/slp_step_timer.sv
module slp_step_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/slp_line_decode.sv
module slp_line_decode
    import slp_pkg::*;
(
    input  logic [LVL_W-1:0]     level,
    output logic [NUM_LINES-1:0] lines_n
);

    // line i is asserted (low) whenever more than i steps are active
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign lines_n[i] = !(level > LVL_W'(i));
    end

endmodule

// File: rtl/slp_seq_fsm.sv
module slp_seq_fsm
    import slp_pkg::*;
#(
    parameter gap_arr_t STEP_GAP = '{3, 2, 4, 1, 5, 2, 3},
    parameter int       CW       = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_ok,
    input  logic             resume_on_power,
    input  logic             sleep_go,
    input  logic [1:0]       sleep_kind,
    input  logic             wake_evt,
    input  logic             link_ack,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CW-1:0]    tmr_val,
    output logic [LVL_W-1:0] level,
    output logic             link_req,
    output logic [1:0]       gstate
);

    localparam logic [LVL_W-1:0] FULL = LVL_W'(NUM_LINES);
    localparam seq_regs_t OFF_REGS = '{
        st: ST_OFF, level: FULL, target: FULL, req: 1'b0, gs: GS_MECH
    };

    seq_regs_t        r, n;
    logic [LVL_W-1:0] gap_idx;

    always_comb begin
        n = r;
        unique case (r.st)
            ST_OFF: begin
                if (resume_on_power) begin
                    n.st    = ST_WORK;
                    n.level = '0;
                    n.gs    = GS_WORK;
                end else begin
                    n.st     = ST_REST;
                    n.target = FULL;
                    n.gs     = GS_SOFT;
                end
            end
            ST_WORK: begin
                if (sleep_go) begin
                    n.st     = ST_DOWN;
                    n.level  = LVL_W'(1);
                    n.target = depth_of(sleep_kind_e'(sleep_kind));
                end
            end
            ST_DOWN: begin
                if (tmr_expired) begin
                    if (r.level == r.target) begin
                        n.st = ST_REST;
                        n.gs = (r.target == FULL) ? GS_SOFT : GS_SLEEP;
                    end else if (r.level == LVL_W'(HAND_LEVEL)) begin
                        n.st  = ST_HAND;
                        n.req = 1'b1;
                    end else begin
                        n.level = r.level + 1'b1;
                    end
                end
            end
            ST_HAND: begin
                if (link_ack) begin
                    n.st    = ST_DOWN;
                    n.level = r.level + 1'b1;
                end
            end
            ST_REST: begin
                if (wake_evt) begin
                    n.st    = ST_UP;
                    n.level = r.level - 1'b1;
                end
            end
            ST_UP: begin
                if (tmr_expired) begin
                    n.level = r.level - 1'b1;
                    if (r.level == LVL_W'(1)) begin
                        n.st  = ST_RELEASE;
                        n.req = 1'b0;
                    end
                end
            end
            ST_RELEASE: begin
                if (!link_ack) begin
                    n.st = ST_WORK;
                    n.gs = GS_WORK;
                end
            end
            default: n = OFF_REGS;
        endcase
        if (!pwr_ok) begin
            n = OFF_REGS;
        end
    end

    // every change of level starts the hold time of the new level
    always_comb begin
        gap_idx  = (n.level == '0) ? '0 : n.level - 1'b1;
        tmr_load = pwr_ok && (n.level != r.level) && (n.level != '0);
        tmr_val  = CW'(STEP_GAP[gap_idx] - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r <= OFF_REGS;
        end else begin
            r <= n;
        end
    end

    assign level    = r.level;
    assign link_req = r.req;
    assign gstate   = r.gs;

endmodule

// File: rtl/slp_seq_top.sv
module slp_seq_top
    import slp_pkg::*;
#(
    parameter gap_arr_t STEP_GAP = '{3, 2, 4, 1, 5, 2, 3}
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_ok,
    input  logic       resume_on_power,
    input  logic       sleep_go,
    input  logic [1:0] sleep_kind,
    input  logic       wake_evt,
    input  logic       link_ack,
    output logic       link_req,
    output logic       stop_clk_n,
    output logic       cpu_sleep_n,
    output logic       suspend_n,
    output logic       plat_rst_n,
    output logic       sleep3_n,
    output logic       sleep4_n,
    output logic       sleep5_n,
    output logic [1:0] gstate
);

    localparam int unsigned GAP_MAX = max_gap(STEP_GAP);
    localparam int          CW      = $clog2(GAP_MAX + 1);

    logic                 tmr_load;
    logic [CW-1:0]        tmr_val;
    logic                 tmr_expired;
    logic [LVL_W-1:0]     level;
    logic [NUM_LINES-1:0] lines_n;

    slp_seq_fsm #(
        .STEP_GAP (STEP_GAP),
        .CW       (CW)
    ) u_fsm (
        .clk             (clk),
        .rst             (rst),
        .pwr_ok          (pwr_ok),
        .resume_on_power (resume_on_power),
        .sleep_go        (sleep_go),
        .sleep_kind      (sleep_kind),
        .wake_evt        (wake_evt),
        .link_ack        (link_ack),
        .tmr_expired     (tmr_expired),
        .tmr_load        (tmr_load),
        .tmr_val         (tmr_val),
        .level           (level),
        .link_req        (link_req),
        .gstate          (gstate)
    );

    slp_step_timer #(
        .CW (CW)
    ) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    slp_line_decode u_dec (
        .level   (level),
        .lines_n (lines_n)
    );

    assign stop_clk_n  = lines_n[0];
    assign cpu_sleep_n = lines_n[1];
    assign suspend_n   = lines_n[2];
    assign plat_rst_n  = lines_n[3];
    assign sleep3_n    = lines_n[4];
    assign sleep4_n    = lines_n[5];
    assign sleep5_n    = lines_n[6];

endmodule

// File: rtl/slp_seq_chk.sv
module slp_seq_chk
    import slp_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 pwr_ok,
    input logic                 resume_on_power,
    input logic                 link_ack,
    input logic                 link_req,
    input logic [NUM_LINES-1:0] lines_n,
    input logic [1:0]           gstate
);

    logic [NUM_LINES-1:0] on;
    assign on = ~lines_n;

    // R4: asserted lines always form an unbroken prefix of the order
    a_r4_prefix: assert property (@(posedge clk) disable iff (rst)
        (on & (on + 1'b1)) == '0);

    // R4: with power steady, at most one line changes per cycle
    a_r4_one_step: assert property (@(posedge clk) disable iff (rst)
        (pwr_ok && $past(pwr_ok) && $past(gstate) != GS_MECH)
        |-> $countones(lines_n ^ $past(lines_n)) <= 1);

    // R10: power loss forces mechanical off with everything asserted
    a_r10_power_loss: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |=> (gstate == GS_MECH && lines_n == '0 && !link_req));

    // R2: power return lands where the policy bit says
    a_r2_return: assert property (@(posedge clk) disable iff (rst)
        ($past(pwr_ok) && !$past(pwr_ok, 2))
        |-> gstate == ($past(resume_on_power) ? GS_WORK : GS_SOFT));

    // R6: processor sleep only follows a granted link request
    a_r6_cpu_after_ack: assert property (@(posedge clk) disable iff (rst)
        (pwr_ok && $past(pwr_ok) && $fell(lines_n[1]))
        |-> ($past(link_ack) && $past(link_req)));

    // R8: the link request is withdrawn together with the last release
    a_r8_req_drop: assert property (@(posedge clk) disable iff (rst)
        (pwr_ok && $rose(lines_n[0]) && $past(gstate) != GS_MECH)
        |-> !link_req);

    // R8: working is re-entered from a sleep only once the acknowledge is gone
    a_r8_work_ack_low: assert property (@(posedge clk) disable iff (rst)
        (gstate == GS_WORK && $past(gstate) != GS_WORK && $past(gstate) != GS_MECH)
        |-> !$past(link_ack));

endmodule

bind slp_seq_top slp_seq_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .pwr_ok          (pwr_ok),
    .resume_on_power (resume_on_power),
    .link_ack        (link_ack),
    .link_req        (link_req),
    .lines_n         ({sleep5_n, sleep4_n, sleep3_n, plat_rst_n,
                       suspend_n, cpu_sleep_n, stop_clk_n}),
    .gstate          (gstate)
);

// File: tb/sim_slp_seq_top.sv
`timescale 1ns/1ps
module sim_slp_seq_top;

    localparam int unsigned G [7] = '{3, 2, 4, 1, 5, 2, 3};

    logic       clk = 1'b0;
    logic       rst;
    logic       pwr_ok;
    logic       resume_on_power;
    logic       sleep_go;
    logic [1:0] sleep_kind;
    logic       wake_evt;
    logic       link_ack;
    logic       link_req;
    logic       stop_clk_n, cpu_sleep_n, suspend_n, plat_rst_n;
    logic       sleep3_n, sleep4_n, sleep5_n;
    logic [1:0] gstate;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int t_ack = -1;
    int t_ackfall = -1;
    int wcnt = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    slp_seq_top #(.STEP_GAP(G)) u0 (
        .clk (clk), .rst (rst), .pwr_ok (pwr_ok),
        .resume_on_power (resume_on_power), .sleep_go (sleep_go),
        .sleep_kind (sleep_kind), .wake_evt (wake_evt), .link_ack (link_ack),
        .link_req (link_req), .stop_clk_n (stop_clk_n), .cpu_sleep_n (cpu_sleep_n),
        .suspend_n (suspend_n), .plat_rst_n (plat_rst_n), .sleep3_n (sleep3_n),
        .sleep4_n (sleep4_n), .sleep5_n (sleep5_n), .gstate (gstate)
    );

    function automatic logic [6:0] asrt();
        return ~{sleep5_n, sleep4_n, sleep3_n, plat_rst_n, suspend_n, cpu_sleep_n, stop_clk_n};
    endfunction

    function automatic int exp_depth(logic [1:0] k);
        case (k)
            2'd0:    return 2;
            2'd1:    return 5;
            2'd2:    return 6;
            default: return 7;
        endcase
    endfunction

    function automatic logic [6:0] exp_mask(int d);
        return 7'((1 << d) - 1);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // link partner: answers link_req after 0..3 cycles
    initial begin
        link_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (link_req !== link_ack) begin
                if (wcnt == 0) begin
                    link_ack = link_req;
                    if (link_ack) t_ack = cyc;
                    else          t_ackfall = cyc;
                end else begin
                    wcnt--;
                end
            end else begin
                wcnt = int'($urandom % 4);
            end
        end
    end

    task automatic do_sleep(input logic [1:0] kind);
        int t [7];
        int treq, trest, d;
        bit order_ok, gap_ok, done;
        logic [6:0] prev, cur;
        d = exp_depth(kind);
        treq = -1; trest = -1; order_ok = 1; gap_ok = 1; done = 0;
        prev = '0; cur = '0;
        for (int i = 0; i < 7; i++) t[i] = -1;
        @(negedge clk); sleep_kind = kind; sleep_go = 1'b1;
        @(negedge clk); sleep_go = 1'b0;
        for (int k = 0; k < 400 && !done; k++) begin
            cur = asrt();
            if (cur != prev) begin
                if (cur == ((prev << 1) | 7'd1)) t[$countones(prev)] = cyc;
                else order_ok = 0;
            end
            if (link_req && treq < 0) treq = cyc;
            prev = cur;
            if (gstate != 2'd0) begin
                trest = cyc;
                done = 1;
            end else begin
                @(negedge clk);
            end
        end
        chk(done, "R11", "entry reached rest", int'(done), 1);
        chk(cur == exp_mask(d), "R3", "resting line mask", int'(cur), int'(exp_mask(d)));
        chk(gstate == ((kind == 2'd3) ? 2'd2 : 2'd1), "R3", "resting gstate",
            int'(gstate), (kind == 2'd3) ? 2 : 1);
        chk(order_ok, "R4", "entry order", int'(order_ok), 1);
        chk(treq - t[0] == int'(G[0]), "R6", "request delay", treq - t[0], int'(G[0]));
        chk(t[1] - t_ack == 1, "R6", "cpu sleep after ack", t[1] - t_ack, 1);
        for (int i = 2; i < d; i++) begin
            if (t[i] - t[i-1] != int'(G[i-1])) gap_ok = 0;
        end
        chk(gap_ok, "R5", "entry spacing", int'(gap_ok), 1);
        chk(trest - t[d-1] == int'(G[d-1]), "R11", "rest code timing",
            trest - t[d-1], int'(G[d-1]));
    endtask

    task automatic do_wake();
        int e [8];
        int m, cw, tw, texp;
        bit ok, gap_ok, req_low, done;
        logic [6:0] prev, cur;
        prev = asrt(); m = $countones(prev);
        ok = 1; gap_ok = 1; req_low = 0; done = 0; tw = -1;
        for (int i = 0; i < 8; i++) e[i] = -1;
        t_ackfall = -1;
        cw = cyc; wake_evt = 1'b1;
        @(negedge clk); wake_evt = 1'b0;
        for (int k = 0; k < 400 && !done; k++) begin
            cur = asrt();
            if (cur != prev) begin
                if (cur == (prev >> 1)) e[$countones(cur)] = cyc;
                else ok = 0;
                if (cur == '0) req_low = !link_req;
            end
            if (gstate != 2'd0 && cur == '0 && prev == '0 && gstate == 2'd3) ok = 0;
            prev = cur;
            if (gstate == 2'd0) begin
                tw = cyc;
                done = 1;
            end else begin
                @(negedge clk);
            end
        end
        chk(ok, "R7", "reverse release order", int'(ok), 1);
        chk(e[m-1] == cw + 1, "R7", "first release timing", e[m-1], cw + 1);
        for (int j = 1; j < m; j++) begin
            if (e[j-1] - e[j] != int'(G[j-1])) gap_ok = 0;
        end
        chk(gap_ok, "R7", "exit spacing", int'(gap_ok), 1);
        chk(req_low, "R8", "request drops with last line", int'(req_low), 1);
        texp = ((t_ackfall > e[0]) ? t_ackfall : e[0]) + 1;
        chk(tw == texp, "R8", "working after ack low", tw, texp);
        chk(asrt() == '0, "R8", "all released in working", int'(asrt()), 0);
    endtask

    initial begin
        logic [6:0] snap;
        logic [1:0] kind;
        void'($urandom(32'd1234));
        rst = 1'b1; pwr_ok = 1'b0; resume_on_power = 1'b0;
        sleep_go = 1'b0; sleep_kind = 2'd0; wake_evt = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(gstate == 2'd3, "R1", "reset gstate", int'(gstate), 3);
        chk(asrt() == 7'h7f, "R1", "reset lines", int'(asrt()), 127);
        chk(!link_req, "R1", "reset request", int'(link_req), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(gstate == 2'd3 && asrt() == 7'h7f, "R10", "stays off without power",
            int'(gstate), 3);

        // power returns with policy 0: soft off
        pwr_ok = 1'b1;
        @(negedge clk);
        chk(gstate == 2'd2, "R2", "soft off after return", int'(gstate), 2);
        chk(asrt() == 7'h7f, "R2", "soft off lines", int'(asrt()), 127);
        repeat (2) @(negedge clk);
        do_wake();

        // wake in working is ignored
        wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
        repeat (4) @(negedge clk);
        chk(gstate == 2'd0 && asrt() == '0, "R9", "wake ignored in working",
            int'(asrt()), 0);

        // directed: every kind
        for (int k = 0; k < 4; k++) begin
            do_sleep(2'(k));
            if (k == 1) begin
                snap = asrt();
                sleep_kind = 2'd3; sleep_go = 1'b1;
                @(negedge clk); sleep_go = 1'b0;
                repeat (4) @(negedge clk);
                chk(asrt() == snap && gstate == 2'd1, "R9", "go ignored at rest",
                    int'(asrt()), int'(snap));
            end
            repeat (2) @(negedge clk);
            do_wake();
            repeat (2) @(negedge clk);
        end

        // power loss in the middle of an entry
        sleep_kind = 2'd2; sleep_go = 1'b1;
        @(negedge clk); sleep_go = 1'b0;
        repeat (6) @(negedge clk);
        pwr_ok = 1'b0;
        @(negedge clk);
        chk(gstate == 2'd3 && asrt() == 7'h7f && !link_req, "R10",
            "power loss mid entry", int'(gstate), 3);
        repeat (3) @(negedge clk);
        resume_on_power = 1'b1; pwr_ok = 1'b1;
        @(negedge clk);
        chk(gstate == 2'd0, "R2", "working after return", int'(gstate), 0);
        chk(asrt() == '0, "R2", "lines released after return", int'(asrt()), 0);
        repeat (10) @(negedge clk);

        // random kinds and idle gaps
        for (int it = 0; it < 16; it++) begin
            kind = 2'($urandom % 4);
            repeat (int'($urandom % 6)) @(negedge clk);
            do_sleep(kind);
            repeat (int'($urandom % 6)) @(negedge clk);
            do_wake();
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", cyc, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule